// File: doc/BRIEF.md
# Pixel Array Scan Address Sequencer

This block produces the row and column addresses that step a multiplexed pixel array through one readout frame. Software sets up the mode and its geometry registers and pulses `start`. From then on the block emits one pixel address on every cycle where `pix_en` is high. Each address carries a read strobe or a reset strobe, a tag that marks guide-window data, and markers for the first pixel of the frame, the last pixel of each row and the last pixel of the frame. When the frame ends the block goes idle and waits for the next `start`.

Five scan patterns are available:
- a complete raster of the array;
- a single rectangular window, clipped to the array;
- a strided subsample that spans the whole field;
- a single chosen pixel, either read or reset;
- a guide pattern that breaks up the full-field raster with repeated passes over a small window.

In the guide pattern the window passes are extra addresses in the same stream. They make the frame longer and do not replace any full-field pixel.

Top module: `scan_seq`

## Requirements
- R1: After reset, and until `start` is seen, `pix_vld`, `pix_rst`, `win_tag`, `sof`, `eor` and `eof` are all low.
- R2: Mode 0 (full) emits every pixel in row-major order, row 0 first and column 0 first within a row. `sof` is set on the first pixel, `eor` on column COLS-1 and `eof` on the final pixel. After the final pixel the block emits nothing more until the next `start`.
- R3: On a cycle with `pix_en` low the block emits nothing and the scan position does not move. The next enabled cycle emits the pixel that was pending.
- R4: Mode 1 (window) scans rows `win_row` to `win_row+win_h-1` and columns `win_col` to `win_col+win_w-1` with `win_tag` high. A size of 0 counts as 1. Any part past the last row or column is clipped at the array edge.
- R5: Mode 2 (subsample) scans rows 0, s, 2s, ... below ROWS with s = `row_skip`, and columns 0, t, 2t, ... below COLS with t = `col_skip`. A stride of 0 counts as 1. `eor` is set on the last column visited and `eof` on the last row's last column.
- R6: Mode 3 (guide) runs the full-field raster with `win_tag` low. Each time `guide_rows` full rows have completed (0 counts as 1), one complete window pass with `win_tag` high is inserted before the next full row. This includes a pass after the final row when that row completes a group. A frame therefore lasts ROWS*COLS + floor(ROWS/N)*(window area) enabled cycles.
- R7: Mode 4 (single pixel) emits only the address (`pick_row`, `pick_col`), clamped to the array. It raises `pix_rst` when `pick_clear` is 1 and `pix_vld` when it is 0, with `sof`, `eor` and `eof` all high.
- R8: Mode and geometry inputs are captured only when `start` is accepted while idle. Changes to them during a frame, and `start` pulses during a frame, have no effect on that frame.
- R9: `pix_vld` and `pix_rst` are never high together, and every emitted address lies inside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| pix_en | input | 1 | Pixel-rate enable; one address per high cycle |
| mode | input | 3 | 0 full, 1 window, 2 subsample, 3 guide, 4 single pixel |
| win_row | input | RW | Window first row |
| win_col | input | CW | Window first column |
| win_h | input | RW+1 | Window height in rows |
| win_w | input | CW+1 | Window width in columns |
| row_skip | input | RW | Subsample row stride |
| col_skip | input | CW | Subsample column stride |
| guide_rows | input | RW | Full rows between guide window passes |
| pick_row | input | RW | Single-pixel row |
| pick_col | input | CW | Single-pixel column |
| pick_clear | input | 1 | Single pixel: 1 reset, 0 read |
| row_addr | output | RW | Current row address |
| col_addr | output | CW | Current column address |
| pix_vld | output | 1 | Read strobe for the current address |
| pix_rst | output | 1 | Reset strobe for the current address |
| win_tag | output | 1 | Current address belongs to a window pass |
| sof | output | 1 | First pixel of the frame |
| eor | output | 1 | Last pixel of a row |
| eof | output | 1 | Last pixel of the frame |

## Verification
The embedded properties check four things on every cycle:
- read and reset strobes are never both high, and addresses stay inside the array;
- the scan position is frozen while the enable is low;
- tagged addresses lie inside the clipped window, and the captured geometry stays constant for the whole frame;
- a single-pixel reset carries all three markers, and nothing is emitted after an end-of-frame.

Only the bench scenarios can show that the visiting order is right. This covers the raster order, the stride lattice, the exact points where guide passes are inserted, the clipped bounds and the total frame length with guide overhead. The bench compares every emitted address and marker against sequences it computes itself, with enable gaps placed throughout.

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pix_en,
  input  logic [2:0]    mode,
  input  logic [RW-1:0] win_row,
  input  logic [CW-1:0] win_col,
  input  logic [RW:0]   win_h,
  input  logic [CW:0]   win_w,
  input  logic [RW-1:0] row_skip,
  input  logic [CW-1:0] col_skip,
  input  logic [RW-1:0] guide_rows,
  input  logic [RW-1:0] pick_row,
  input  logic [CW-1:0] pick_col,
  input  logic          pick_clear,
  output logic [RW-1:0] row_addr,
  output logic [CW-1:0] col_addr,
  output logic          pix_vld,
  output logic          pix_rst,
  output logic          win_tag,
  output logic          sof,
  output logic          eor,
  output logic          eof
);
  localparam logic [RW:0] RMAX = (RW+1)'(ROWS - 1);
  localparam logic [CW:0] CMAX = (CW+1)'(COLS - 1);

  logic          active, in_win, first, tail;
  logic [RW-1:0] rr, save_r, grp;
  logic [CW-1:0] cc;
  logic [2:0]    lm;
  logic [RW-1:0] lr0, lr1, lrs, ln;
  logic [CW-1:0] lc0, lc1, lcs;
  logic          lpk;

  // geometry captured at start, clipped to the array
  logic [RW:0] r_end, c_end;
  logic [RW-1:0] r_org, r_lim, p_row;
  logic [CW-1:0] c_org, c_lim, p_col;
  assign r_end = {1'b0, win_row} + ((win_h == '0) ? (RW+1)'(1) : win_h) - (RW+1)'(1);
  assign c_end = {1'b0, win_col} + ((win_w == '0) ? (CW+1)'(1) : win_w) - (CW+1)'(1);
  assign r_org = ({1'b0, win_row} > RMAX) ? RMAX[RW-1:0] : win_row;
  assign c_org = ({1'b0, win_col} > CMAX) ? CMAX[CW-1:0] : win_col;
  assign r_lim = (r_end > RMAX) ? RMAX[RW-1:0] : r_end[RW-1:0];
  assign c_lim = (c_end > CMAX) ? CMAX[CW-1:0] : c_end[CW-1:0];
  assign p_row = ({1'b0, pick_row} > RMAX) ? RMAX[RW-1:0] : pick_row;
  assign p_col = ({1'b0, pick_col} > CMAX) ? CMAX[CW-1:0] : pick_col;

  // current region
  logic emit, is_rnd, is_guide, use_win, use_sub;
  logic [RW-1:0] rhi, rs;
  logic [CW-1:0] clo, chi, cs;
  logic [RW:0] r_next;
  logic [CW:0] c_next;
  logic last_row, last_col, grp_hit, fin;

  assign emit     = active & pix_en;
  assign is_rnd   = (lm == 3'd4);
  assign is_guide = (lm == 3'd3);
  assign use_win  = in_win | (lm == 3'd1);
  assign use_sub  = (lm == 3'd2);
  assign rhi = use_win ? lr1 : RMAX[RW-1:0];
  assign clo = use_win ? lc0 : '0;
  assign chi = use_win ? lc1 : CMAX[CW-1:0];
  assign rs  = use_sub ? lrs : RW'(1);
  assign cs  = use_sub ? lcs : CW'(1);
  assign r_next   = {1'b0, rr} + {1'b0, rs};
  assign c_next   = {1'b0, cc} + {1'b0, cs};
  assign last_row = r_next > {1'b0, rhi};
  assign last_col = c_next > {1'b0, chi};
  assign grp_hit  = is_guide & ~in_win & (({1'b0, grp} + (RW+1)'(1)) == {1'b0, ln});
  assign fin = is_rnd | (last_row & last_col & (in_win ? tail : ~grp_hit));

  assign row_addr = rr;
  assign col_addr = cc;
  assign pix_vld  = emit & ~(is_rnd & lpk);
  assign pix_rst  = emit & is_rnd & lpk;
  assign win_tag  = emit & use_win;
  assign sof      = emit & first;
  assign eor      = emit & (is_rnd | last_col);
  assign eof      = emit & fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; in_win <= 1'b0; first <= 1'b0; tail <= 1'b0;
      rr <= '0; cc <= '0; save_r <= '0; grp <= '0;
      lm <= '0; lr0 <= '0; lr1 <= '0; lrs <= '0; ln <= '0;
      lc0 <= '0; lc1 <= '0; lcs <= '0; lpk <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1; first <= 1'b1; in_win <= 1'b0; tail <= 1'b0; grp <= '0;
        lm  <= mode;
        lr0 <= r_org; lr1 <= r_lim; lc0 <= c_org; lc1 <= c_lim;
        lrs <= (row_skip == '0) ? RW'(1) : row_skip;
        lcs <= (col_skip == '0) ? CW'(1) : col_skip;
        ln  <= (guide_rows == '0) ? RW'(1) : guide_rows;
        lpk <= pick_clear;
        rr  <= (mode == 3'd4) ? p_row : (mode == 3'd1) ? r_org : '0;
        cc  <= (mode == 3'd4) ? p_col : (mode == 3'd1) ? c_org : '0;
      end
    end else if (pix_en) begin
      first <= 1'b0;
      if (fin) begin
        active <= 1'b0;
      end else if (!last_col) begin
        cc <= c_next[CW-1:0];
      end else if (grp_hit) begin
        in_win <= 1'b1; grp <= '0; tail <= last_row;
        save_r <= r_next[RW-1:0];
        rr <= lr0; cc <= lc0;
      end else if (in_win && last_row) begin
        in_win <= 1'b0; rr <= save_r; cc <= '0;
      end else begin
        rr <= r_next[RW-1:0]; cc <= clo;
        if (is_guide && !in_win) grp <= grp + RW'(1);
      end
    end
  end

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_vld && pix_rst));
  assert_addr_in_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> ({1'b0, row_addr} <= RMAX && {1'b0, col_addr} <= CMAX));
  assert_hold_without_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pix_en) |=> ($stable(rr) && $stable(cc) && $stable(in_win) && active));
  assert_tag_inside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_tag |-> (rr >= lr0 && rr <= lr1 && cc >= lc0 && cc <= lc1));
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (!active || ($stable(lm) && $stable(lr0) && $stable(lr1) &&
                            $stable(lc0) && $stable(lc1) && $stable(lrs) && $stable(lcs))));
  assert_single_reset_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst |-> (sof && eor && eof));
  assert_sof_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);
  assert_quiet_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !(pix_vld || pix_rst));
endmodule

// File: tb/tb_scan_seq.sv
module tb_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int R = 8;
  localparam int C = 8;

  logic clk = 0, rst_n = 0, start = 0, pix_en = 0;
  logic [2:0] mode = 0;
  logic [2:0] win_row = 0, win_col = 0, row_skip = 0, col_skip = 0, guide_rows = 0;
  logic [2:0] pick_row = 0, pick_col = 0;
  logic [3:0] win_h = 0, win_w = 0;
  logic pick_clear = 0;
  logic [2:0] row_addr, col_addr;
  logic pix_vld, pix_rst, win_tag, sof, eor, eof;

  int checks = 0, fails = 0, npix = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_seq #(.ROWS(R), .COLS(C)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_en(pix_en), .mode(mode),
    .win_row(win_row), .win_col(win_col), .win_h(win_h), .win_w(win_w),
    .row_skip(row_skip), .col_skip(col_skip), .guide_rows(guide_rows),
    .pick_row(pick_row), .pick_col(pick_col), .pick_clear(pick_clear),
    .row_addr(row_addr), .col_addr(col_addr), .pix_vld(pix_vld), .pix_rst(pix_rst),
    .win_tag(win_tag), .sof(sof), .eor(eor), .eof(eof));

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (vld rst tag sof eor eof row col)", req, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {pix_vld, pix_rst, win_tag, sof, eor, eof, row_addr, col_addr};
  endfunction

  task automatic px(int r, int c, bit v, bit rs, bit tg, bit s, bit e, bit f, string req);
    @(negedge clk); pix_en = 1; #1;
    npix++;
    check(req, outs(), {v, rs, tg, s, e, f, 3'(r), 3'(c)});
  endtask

  task automatic gap();
    @(negedge clk); pix_en = 0; #1;
    check("R3", {outs()[11:6], 6'd0}, 12'd0);
  endtask

  task automatic quiet(string req);
    @(negedge clk); pix_en = 1; #1;
    check(req, {outs()[11:6], 6'd0}, 12'd0);
    @(negedge clk); pix_en = 0;
  endtask

  task automatic go();
    @(negedge clk); pix_en = 0; start = 1;
    @(negedge clk); start = 0;
    npix = 0;
  endtask

  task automatic run_rect(int r0, int r1, int c0, int c1, int rs, int cs, bit tg, bit gaps, string req);
    bit first = 1;
    for (int r = r0; r <= r1; r += rs)
      for (int c = c0; c <= c1; c += cs) begin
        if (gaps && ((r + c) % 3 == 0)) gap();
        px(r, c, 1, 0, tg, first, c + cs > c1, (r + rs > r1) && (c + cs > c1), req);
        first = 0;
      end
  endtask

  function automatic int mn(int a, int b); return a < b ? a : b; endfunction

  task automatic window(int r0, int c0, int h, int w, bit gaps);
    mode = 1; win_row = 3'(r0); win_col = 3'(c0); win_h = 4'(h); win_w = 4'(w);
    go();
    run_rect(r0, mn(r0 + (h == 0 ? 1 : h) - 1, R - 1), c0, mn(c0 + (w == 0 ? 1 : w) - 1, C - 1),
             1, 1, 1, gaps, "R4");
    quiet("R4");
  endtask

  task automatic subsample(int s, int t);
    int se = (s == 0) ? 1 : s;
    int te = (t == 0) ? 1 : t;
    mode = 2; row_skip = 3'(s); col_skip = 3'(t);
    go();
    run_rect(0, R - 1, 0, C - 1, se, te, 0, 1, "R5");
    quiet("R5");
  endtask

  task automatic guide(int n, int r0, int c0, int h, int w);
    int ne = (n == 0) ? 1 : n;
    int r1 = mn(r0 + h - 1, R - 1);
    int c1 = mn(c0 + w - 1, C - 1);
    bit first = 1;
    mode = 3; guide_rows = 3'(n); win_row = 3'(r0); win_col = 3'(c0);
    win_h = 4'(h); win_w = 4'(w);
    go();
    for (int r = 0; r < R; r++) begin
      bit ins = ((r + 1) % ne == 0);
      for (int c = 0; c < C; c++) begin
        if (c == 3) gap();
        px(r, c, 1, 0, 0, first, c == C - 1, (r == R - 1) && !ins && (c == C - 1), "R6");
        first = 0;
      end
      if (ins)
        for (int wr = r0; wr <= r1; wr++)
          for (int wc = c0; wc <= c1; wc++)
            px(wr, wc, 1, 0, 1, 0, wc == c1, (r == R - 1) && wr == r1 && wc == c1, "R6");
    end
    checks++;
    if (npix != R * C + (R / ne) * (r1 - r0 + 1) * (c1 - c0 + 1)) begin
      fails++;
      $display("FAIL R6: frame length %0d expected %0d", npix,
               R * C + (R / ne) * (r1 - r0 + 1) * (c1 - c0 + 1));
    end
    quiet("R6");
  endtask

  task automatic single(int r, int c, bit clr);
    mode = 4; pick_row = 3'(r); pick_col = 3'(c); pick_clear = clr;
    go();
    gap();
    px(r, c, !clr, clr, 0, 1, 1, 1, "R7");
    quiet("R7");
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    pix_en = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R1", {outs()[11:6], 6'd0}, 12'd0);
    end
    pix_en = 0;

    mode = 0; go();
    run_rect(0, R - 1, 0, C - 1, 1, 1, 0, 1, "R2");
    quiet("R2");

    window(2, 3, 3, 2, 1);
    window(6, 5, 4, 6, 0);
    window(0, 0, 0, 0, 0);
    window(7, 0, 1, 8, 1);

    subsample(2, 3);
    subsample(3, 1);
    subsample(0, 0);
    subsample(5, 7);

    guide(3, 2, 5, 2, 4);
    guide(4, 1, 1, 2, 2);
    guide(0, 7, 7, 1, 1);

    single(5, 2, 0);
    single(1, 6, 1);

    // R8: config changes and start during a frame do not alter it
    mode = 1; win_row = 1; win_col = 2; win_h = 3; win_w = 3;
    go();
    begin
      bit first = 1;
      int k = 0;
      for (int r = 1; r <= 3; r++)
        for (int c = 2; c <= 4; c++) begin
          if (k == 3) begin
            mode = 0; win_row = 5; win_col = 0; win_h = 1; win_w = 8; start = 1;
          end
          if (k == 5) start = 0;
          px(r, c, 1, 0, 1, first, c == 4, r == 3 && c == 4, "R8");
          first = 0; k++;
        end
    end
    quiet("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule